// File: doc/BRIEF.md
# Word/Byte Register File with Loop Counter

This block holds the programmer-visible registers of a 16-bit processor core. There are four general data registers, four pointer/index registers and an instruction pointer. Each data register can be handled as one 16-bit word or as two independent 8-bit halves. The pointer/index registers are word-only. One of the data registers acts as the loop counter. It has its own decrement path and a zero indication, which a repeat sequencer uses to know when a repeated operation is finished.

The block has one write port and two read ports. Each port is addressed by a 3-bit index plus a byte/word mode bit:
- In word mode, indices 0 to 3 select the data registers and indices 4 to 7 select the pointer/index registers.
- In byte mode, indices 0 to 3 select the low bytes of the data registers and indices 4 to 7 select their high bytes.
- The data registers are numbered accumulator = 0, base = 1, counter = 2, data = 3.
- The pointer/index registers are numbered stack pointer = 4, frame pointer = 5, source index = 6, destination index = 7.

Reads are combinational. A write takes effect at the next rising clock edge. The instruction pointer is loaded from outside and otherwise holds its value. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `wbrf_top`

## Requirements
- R1: While reset is applied and after its release, every data and pointer/index register reads 0000h, the instruction pointer reads 0100h and the counter-zero output is 1.
- R2: A word-mode write (byte mode bit 0) of index i stores all 16 bits of the write data into register i at the next rising edge. Word reads of any index return that register combinationally, and the two read ports are independent.
- R3: A byte-mode write with index 0 to 3 replaces bits 7:0 of data register i with write data bits 7:0 and leaves bits 15:8 of that register unchanged.
- R4: A byte-mode write with index 4 to 7 replaces bits 15:8 of data register (i-4) with write data bits 7:0 and leaves bits 7:0 of that register unchanged.
- R5: A byte-mode read returns the selected byte in bits 7:0 with bits 15:8 zero: index 0 to 3 gives the low byte and index 4 to 7 gives the high byte of data register (index mod 4).
- R6: Pointer/index registers are word-only: a byte-mode write never changes registers 4 to 7 in word view.
- R7: A decrement request reduces the counter register (index 2) by one at the next edge, and 0000h wraps to FFFFh.
- R8: The counter-zero output is 1 exactly when the counter register holds 0000h, so it rises in the cycle after a decrement from 0001h.
- R9: When a decrement request and a write aimed at the counter register (word, or either byte half) occur in the same cycle, only the decrement takes effect. A write to any other register in that cycle still takes effect.
- R10: An instruction-pointer load stores the supplied value at the next edge. Without a load the instruction pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index |
| wr_byte | input | 1 | Write mode: 1 = byte, 0 = word |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| rep_dec | input | 1 | Decrement the counter register |
| cnt_zero | output | 1 | Counter register equals zero |
| rda_idx | input | 3 | Read port A index |
| rda_byte | input | 1 | Read port A mode |
| rda_data | output | 16 | Read port A data |
| rdb_idx | input | 3 | Read port B index |
| rdb_byte | input | 1 | Read port B mode |
| rdb_data | output | 16 | Read port B data |
| ip_ld | input | 1 | Load the instruction pointer |
| ip_next | input | 16 | Value for the instruction pointer |
| ip | output | 16 | Instruction pointer |

## Verification
The bench aims at the byte lanes. It writes one half over a known word and reads both the word and the other half, so a design that drove the whole word on a byte write, or put the high byte in the wrong lane, would show a corrupted neighbour byte. It also issues byte-mode writes at indices 4 to 7 and then reads the pointer registers in word view; a design that decoded the index without the mode bit would overwrite a pointer. On the counter side, it steps the count through 1, 0 and the wrap to FFFFh, and it collides decrements with word, high-byte and other-register writes. A design with the wrong priority would load the written value, and one that blocked the whole write port would lose the unrelated write.

// File: rtl/wbrf_pkg.sv
package wbrf_pkg;
  typedef enum logic [2:0] {
    RI_ACC  = 3'd0,
    RI_BASE = 3'd1,
    RI_CNT  = 3'd2,
    RI_DAT  = 3'd3,
    RI_SP   = 3'd4,
    RI_FP   = 3'd5,
    RI_SRC  = 3'd6,
    RI_DST  = 3'd7
  } reg_id_e;
endpackage

// File: rtl/wbrf_rst_sync.sv
module wbrf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_s = sh_q[STAGES-1];
endmodule

// File: rtl/wbrf_data_bank.sv
module wbrf_data_bank #(
  parameter int unsigned DW      = 16,
  parameter int unsigned NREG    = 4,
  parameter int unsigned CNT_SEL = 2,
  localparam int unsigned BW     = DW / 2,
  localparam int unsigned IW     = $clog2(2 * NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic                     wr_byte,
  input  logic [DW-1:0]            wr_data,
  input  logic                     dec_cnt,
  output logic [NREG-1:0][DW-1:0]  regs,
  output logic                     cnt_zero
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam bit IS_CNT = (g == CNT_SEL);
    logic [DW-1:0] q, d;
    logic lo_hit, hi_hit, dec_hit, en;

    always_comb begin
      lo_hit  = wr_en && (wr_idx == IW'(g));
      hi_hit  = wr_en && (wr_byte ? (wr_idx == IW'(g + NREG)) : (wr_idx == IW'(g)));
      dec_hit = IS_CNT && dec_cnt;
      en      = lo_hit || hi_hit || dec_hit;
      d       = q;
      if (dec_hit) begin
        d = q - DW'(1);
      end else begin
        if (lo_hit) d[BW-1:0] = wr_data[BW-1:0];
        if (hi_hit) d[DW-1:BW] = wr_byte ? wr_data[BW-1:0] : wr_data[DW-1:BW];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign regs[g] = q;
  end

  assign cnt_zero = (regs[CNT_SEL] == '0);
endmodule

// File: rtl/wbrf_ptr_bank.sv
module wbrf_ptr_bank #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 4,
  localparam int unsigned IW  = $clog2(2 * NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic                     wr_byte,
  input  logic [DW-1:0]            wr_data,
  output logic [NREG-1:0][DW-1:0]  regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    logic en;

    always_comb en = wr_en && !wr_byte && (wr_idx == IW'(g + NREG));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end

    assign regs[g] = q;
  end
endmodule

// File: rtl/wbrf_ip_reg.sv
module wbrf_ip_reg #(
  parameter int unsigned    DW      = 16,
  parameter logic [DW-1:0]  RST_VAL = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] nxt,
  output logic [DW-1:0] q
);
  logic [DW-1:0] d;

  always_comb d = nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/wbrf_top.sv
module wbrf_top #(
  parameter int unsigned   DW          = 16,
  parameter int unsigned   NDATA       = 4,
  parameter int unsigned   CNT_SEL     = 2,
  parameter int unsigned   SYNC_STAGES = 2,
  parameter logic [DW-1:0] IP_RESET    = 16'h0100,
  localparam int unsigned  BW          = DW / 2,
  localparam int unsigned  IW          = $clog2(2 * NDATA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_byte,
  input  logic [DW-1:0] wr_data,
  input  logic          rep_dec,
  output logic          cnt_zero,
  input  logic [IW-1:0] rda_idx,
  input  logic          rda_byte,
  output logic [DW-1:0] rda_data,
  input  logic [IW-1:0] rdb_idx,
  input  logic          rdb_byte,
  output logic [DW-1:0] rdb_data,
  input  logic          ip_ld,
  input  logic [DW-1:0] ip_next,
  output logic [DW-1:0] ip
);
  logic                     rst_s;
  logic [NDATA-1:0][DW-1:0] dregs;
  logic [NDATA-1:0][DW-1:0] pregs;

  wbrf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s)
  );

  wbrf_data_bank #(.DW(DW), .NREG(NDATA), .CNT_SEL(CNT_SEL)) u_data (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_byte(wr_byte), .wr_data(wr_data), .dec_cnt(rep_dec),
    .regs(dregs), .cnt_zero(cnt_zero)
  );

  wbrf_ptr_bank #(.DW(DW), .NREG(NDATA)) u_ptr (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_byte(wr_byte), .wr_data(wr_data), .regs(pregs)
  );

  wbrf_ip_reg #(.DW(DW), .RST_VAL(IP_RESET)) u_ip (
    .clk(clk), .rst_n(rst_s), .ld(ip_ld), .nxt(ip_next), .q(ip)
  );

  function automatic logic [DW-1:0] pick(input logic [IW-1:0] idx, input logic byt,
                                         input logic [NDATA-1:0][DW-1:0] dr,
                                         input logic [NDATA-1:0][DW-1:0] pr);
    logic [IW-2:0] lane;
    logic          upper;
    lane  = idx[IW-2:0];
    upper = idx[IW-1];
    if (byt) pick = {{BW{1'b0}}, upper ? dr[lane][DW-1:BW] : dr[lane][BW-1:0]};
    else     pick = upper ? pr[lane] : dr[lane];
  endfunction

  always_comb begin
    rda_data = pick(rda_idx, rda_byte, dregs, pregs);
    rdb_data = pick(rdb_idx, rdb_byte, dregs, pregs);
  end
endmodule

// File: rtl/wbrf_chk.sv
module wbrf_chk #(
  parameter int unsigned  DW      = 16,
  parameter int unsigned  NDATA   = 4,
  parameter int unsigned  CNT_SEL = 2,
  localparam int unsigned BW      = DW / 2,
  localparam int unsigned IW      = $clog2(2 * NDATA),
  localparam int unsigned LW      = IW - 1
) (
  input logic                     clk,
  input logic                     rst_s,
  input logic                     wr_en,
  input logic [IW-1:0]            wr_idx,
  input logic                     wr_byte,
  input logic                     rep_dec,
  input logic                     ip_ld,
  input logic [DW-1:0]            ip_next,
  input logic [DW-1:0]            ip,
  input logic                     cnt_zero,
  input logic [NDATA-1:0][DW-1:0] dregs,
  input logic [NDATA-1:0][DW-1:0] pregs
);
  logic [LW-1:0] lane;
  logic          cnt_hit;
  assign lane    = wr_idx[LW-1:0];
  assign cnt_hit = rep_dec && (lane == LW'(CNT_SEL));

  // R3: a low-byte write keeps the high byte
  p_lo_keep_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && wr_byte && !wr_idx[IW-1] && !cnt_hit) |=>
      dregs[$past(lane)][DW-1:BW] == $past(dregs[lane][DW-1:BW]));

  // R4: a high-byte write keeps the low byte
  p_hi_keep_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && wr_byte && wr_idx[IW-1] && !cnt_hit) |=>
      dregs[$past(lane)][BW-1:0] == $past(dregs[lane][BW-1:0]));

  // R6: byte-mode writes never touch pointer/index registers
  p_ptr_word_only_r6: assert property (@(posedge clk) disable iff (!rst_s)
    wr_byte |=> $stable(pregs));

  // R7 and R9: a decrement wins over any write to the counter
  p_dec_r7: assert property (@(posedge clk) disable iff (!rst_s)
    rep_dec |=> dregs[CNT_SEL] == $past(dregs[CNT_SEL]) - DW'(1));

  // R8: reaching zero raises the zero flag
  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (rep_dec && dregs[CNT_SEL] == DW'(1)) |=> cnt_zero);

  // R10: load and hold of the instruction pointer
  p_ip_load_r10: assert property (@(posedge clk) disable iff (!rst_s)
    ip_ld |=> ip == $past(ip_next));

  p_ip_hold_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !ip_ld |=> $stable(ip));
endmodule

bind wbrf_top wbrf_chk #(.DW(DW), .NDATA(NDATA), .CNT_SEL(CNT_SEL)) chk_i (
  .clk(clk), .rst_s(rst_s), .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte),
  .rep_dec(rep_dec), .ip_ld(ip_ld), .ip_next(ip_next), .ip(ip),
  .cnt_zero(cnt_zero), .dregs(dregs), .pregs(pregs)
);

// File: tb/wbrf_top_tb_top.sv
module wbrf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_byte, rep_dec, ip_ld;
  logic [2:0]  wr_idx, rda_idx, rdb_idx;
  logic        rda_byte, rdb_byte;
  logic [15:0] wr_data, ip_next;
  logic        cnt_zero;
  logic [15:0] rda_data, rdb_data, ip;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] exp_a;
    logic [15:0] exp_b;
    logic [15:0] exp_ip;
    logic        exp_zero;
    string       tag;
  } item_t;

  item_t sbq[$];

  logic [15:0] mdat [4];
  logic [15:0] mptr [4];
  logic [15:0] mip;

  always #5 clk = ~clk;

  wbrf_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .wr_data(wr_data), .rep_dec(rep_dec), .cnt_zero(cnt_zero),
    .rda_idx(rda_idx), .rda_byte(rda_byte), .rda_data(rda_data),
    .rdb_idx(rdb_idx), .rdb_byte(rdb_byte), .rdb_data(rdb_data),
    .ip_ld(ip_ld), .ip_next(ip_next), .ip(ip)
  );

  function automatic logic [15:0] mread(input logic [2:0] idx, input logic byt);
    if (byt) return idx[2] ? {8'h00, mdat[idx[1:0]][15:8]} : {8'h00, mdat[idx[1:0]][7:0]};
    return idx[2] ? mptr[idx[1:0]] : mdat[idx[1:0]];
  endfunction

  task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        cmp(it.tag, "rda_data", rda_data, it.exp_a);
        cmp(it.tag, "rdb_data", rdb_data, it.exp_b);
        cmp(it.tag, "ip", ip, it.exp_ip);
        cmp(it.tag, "cnt_zero", {15'd0, cnt_zero}, {15'd0, it.exp_zero});
      end
    end
  end

  // one write-side cycle; model updated per the requirements
  task automatic op(input logic we, input logic [2:0] idx, input logic byt,
                    input logic [15:0] wd, input logic dec,
                    input logic ild, input logic [15:0] ind);
    logic cnt_blk;
    @(negedge clk);
    wr_en = we; wr_idx = idx; wr_byte = byt; wr_data = wd;
    rep_dec = dec; ip_ld = ild; ip_next = ind;
    cnt_blk = dec && (idx[1:0] == 2'd2) && (byt || !idx[2]);
    if (we && !cnt_blk) begin
      if (byt) begin
        if (idx[2]) mdat[idx[1:0]][15:8] = wd[7:0];
        else        mdat[idx[1:0]][7:0]  = wd[7:0];
      end else if (idx[2]) mptr[idx[1:0]] = wd;
      else                 mdat[idx[1:0]] = wd;
    end
    if (dec) mdat[2] = mdat[2] - 16'd1;
    if (ild) mip = ind;
  endtask

  // read-side cycle with writes idle; expected values pushed to scoreboard
  task automatic chk(input logic [2:0] ia, input logic ba,
                     input logic [2:0] ib, input logic bb, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0; rep_dec = 1'b0; ip_ld = 1'b0;
    rda_idx = ia; rda_byte = ba; rdb_idx = ib; rdb_byte = bb;
    it.exp_a    = mread(ia, ba);
    it.exp_b    = mread(ib, bb);
    it.exp_ip   = mip;
    it.exp_zero = (mdat[2] == 16'h0000);
    it.tag      = tag;
    sbq.push_back(it);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired before the sequence finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; wr_idx = '0; wr_byte = 1'b0; wr_data = '0;
    rep_dec = 1'b0; ip_ld = 1'b0; ip_next = '0;
    rda_idx = '0; rda_byte = 1'b0; rdb_idx = '0; rdb_byte = 1'b0;
    for (int i = 0; i < 4; i++) begin mdat[i] = '0; mptr[i] = '0; end
    mip = 16'h0100;

    // R1: state while reset is held
    chk(3'd0, 1'b0, 3'd7, 1'b0, "R1");
    chk(3'd2, 1'b0, 3'd5, 1'b1, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(3'd4, 1'b0, 3'd3, 1'b0, "R1");

    // R2 and R5: word write, word and byte reads
    op(1'b1, 3'd0, 1'b0, 16'h1234, 1'b0, 1'b0, 16'h0);
    chk(3'd0, 1'b0, 3'd4, 1'b1, "R2");
    chk(3'd0, 1'b1, 3'd4, 1'b0, "R5");
    op(1'b1, 3'd5, 1'b0, 16'hBEEF, 1'b0, 1'b0, 16'h0);
    op(1'b1, 3'd7, 1'b0, 16'hA55A, 1'b0, 1'b0, 16'h0);
    chk(3'd5, 1'b0, 3'd7, 1'b0, "R2");

    // R3: low-byte write keeps the high byte
    op(1'b1, 3'd1, 1'b0, 16'h1111, 1'b0, 1'b0, 16'h0);
    op(1'b1, 3'd1, 1'b1, 16'h55AB, 1'b0, 1'b0, 16'h0);
    chk(3'd1, 1'b0, 3'd1, 1'b1, "R3");

    // R4: high-byte write keeps the low byte
    op(1'b1, 3'd3, 1'b0, 16'h4321, 1'b0, 1'b0, 16'h0);
    op(1'b1, 3'd7, 1'b1, 16'h99CD, 1'b0, 1'b0, 16'h0);
    chk(3'd3, 1'b0, 3'd7, 1'b1, "R4");

    // R6: byte-mode writes at 4..7 leave pointer registers alone
    op(1'b1, 3'd5, 1'b1, 16'h0077, 1'b0, 1'b0, 16'h0);
    chk(3'd5, 1'b0, 3'd1, 1'b0, "R6");
    op(1'b1, 3'd4, 1'b1, 16'h00EE, 1'b0, 1'b0, 16'h0);
    chk(3'd4, 1'b0, 3'd7, 1'b0, "R6");

    // R7 and R8: count down to zero and wrap
    op(1'b1, 3'd2, 1'b0, 16'h0002, 1'b0, 1'b0, 16'h0);
    chk(3'd2, 1'b0, 3'd6, 1'b1, "R8");
    op(1'b0, 3'd0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
    chk(3'd2, 1'b0, 3'd2, 1'b1, "R7");
    op(1'b0, 3'd0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
    chk(3'd2, 1'b0, 3'd6, 1'b1, "R8");
    op(1'b0, 3'd0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
    chk(3'd2, 1'b0, 3'd6, 1'b1, "R7");

    // R9: decrement beats writes to the counter; other writes proceed
    op(1'b1, 3'd2, 1'b0, 16'h0050, 1'b1, 1'b0, 16'h0);
    chk(3'd2, 1'b0, 3'd6, 1'b1, "R9");
    op(1'b1, 3'd6, 1'b1, 16'h0033, 1'b1, 1'b0, 16'h0);
    chk(3'd2, 1'b0, 3'd2, 1'b1, "R9");
    op(1'b1, 3'd0, 1'b0, 16'h9999, 1'b1, 1'b0, 16'h0);
    chk(3'd0, 1'b0, 3'd2, 1'b0, "R9");

    // R10: instruction pointer load and hold
    op(1'b0, 3'd0, 1'b0, 16'h0, 1'b0, 1'b1, 16'h2000);
    chk(3'd0, 1'b0, 3'd1, 1'b0, "R10");
    op(1'b0, 3'd0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h3333);
    chk(3'd4, 1'b0, 3'd5, 1'b0, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule